// File: doc/BRIEF.md
# Serial Shift and Dual-Latch Loader

This block is the serial front end of a 16-channel LED driver. A 257-bit shift register takes one bit from `sin` for each rising edge on `sclk`. The bit at the top of the register appears on `sout`, so several drivers can be wired in a chain. A rising edge on `lat` moves the register into one of two first-stage latches, and the top bit picks which one: the grayscale latch (16 channels of 16 bits) or the control latch. The control latch holds dot correction, global brightness and a timing-restart bit.

A second stage feeds the PWM engine. It holds the grayscale data and the dot-correction/brightness data. Normally the grayscale second stage takes the first stage at the end of each display period. When the timing-restart bit is set, a grayscale write loads both grayscale stages at once. The same write moves the correction and brightness fields to the second stage and sends a one-cycle restart pulse to the grayscale counter. One clock after any latch event, the register is reloaded with fault status so that the host can read it out serially.

All inputs are sampled in one system clock domain. The reset is asynchronous and active-low, and it is released synchronously.

Top module: `serial_dual_latch`

## Requirements
- R1: Each rising edge seen on `sclk` shifts the register one place toward its top bit and puts the `sin` value into bit 0. The register does not change unless there is an `sclk` edge or a status load.
- R2: `sout` always equals register bit 256. After 257 shifts it shows the first bit that was shifted in.
- R3: A `lat` rising edge with bit 256 = 0 stores bits 255:0 into the grayscale first stage. Channel n occupies bits 16n+15:16n.
- R4: A `lat` rising edge with bit 256 = 1 stores bits 120:0 into the control first stage and leaves `gs_data`, `dc_data` and `bc_data` unchanged. In that word, bits 7n+6:7n hold the dot correction of channel n, bits 119:112 hold the brightness and bit 120 is the timing-restart bit.
- R5: When the stored timing-restart bit is 1, a grayscale write updates `gs_data` to the new word without waiting for a period end. In the same cycle it copies dot correction and brightness to `dc_data`/`bc_data`, and `gs_restart` is high for exactly one cycle.
- R6: When the timing-restart bit is 0, a grayscale write changes neither `gs_data`, `dc_data` nor `bc_data`, and it produces no `gs_restart` pulse.
- R7: A `period_end` cycle copies the grayscale first stage to `gs_data`. `gs_data` changes only after a `lat` edge or a `period_end`.
- R8: One clock after every latch event, the register is loaded with status: open flags in bits 15:0, short flags in 31:16, leak flags in 47:32, thermal error in bit 48, reference short in bit 49, and zeros above. This leaves `sout` at 0.
- R9: Reset clears the register, all latches and `gs_restart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial shift clock level, sampled by `clk` |
| sin | input | 1 | Serial data in |
| lat | input | 1 | Latch strobe level, sampled by `clk` |
| period_end | input | 1 | One-cycle end-of-display-period strobe from the PWM engine |
| led_open | input | 16 | Per-channel open-LED flags |
| led_short | input | 16 | Per-channel shorted-LED flags |
| out_leak | input | 16 | Per-channel output leakage flags |
| therm_err | input | 1 | Thermal error flag |
| iref_short | input | 1 | Reference pin short flag |
| sout | output | 1 | Serial data out (register top bit) |
| gs_data | output | 256 | Second-stage grayscale data |
| dc_data | output | 112 | Second-stage dot correction |
| bc_data | output | 8 | Second-stage brightness |
| gs_restart | output | 1 | One-cycle grayscale counter restart pulse |

## Verification
A wrong shift or load state inside the register shows up on `sout`. A fault in a bit near the top is visible within a shift or two. A fault near bit 0 stays hidden until the full 257-bit readout, so the checks compare whole frames and whole status readouts rather than single bits. A wrong first-stage grayscale or control latch cannot be seen at the ports until a later `period_end` or restart write moves it to the second stage. For that reason, every first-stage write is followed by one of those transfers and then a compare of the whole output word. A stuck timing-restart bit shows up on the very next grayscale write: `gs_data` either moves too early or fails to move, and `gs_restart` pulses when it should not or stays low when it should pulse.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int unsigned CH_DEF  = 16;
  localparam int unsigned GSW_DEF = 16;
  localparam int unsigned DCW_DEF = 7;
  localparam int unsigned BCW_DEF = 8;

  // Source selection for the grayscale second stage
  typedef enum logic [1:0] {
    SRC_HOLD   = 2'd0,
    SRC_BUS    = 2'd1,
    SRC_STAGE1 = 2'd2
  } gs2_src_e;
endpackage

// File: rtl/sdl_rst_sync.sv
module sdl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/sdl_edge_det.sv
module sdl_edge_det #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lvl,
  output logic [LANES-1:0] rise
);
  logic [LANES-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= lvl;
      s2_q <= s1_q;
    end
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign rise[i] = s1_q[i] & ~s2_q[i];
    end
  endgenerate
endmodule

// File: rtl/sdl_shift_reg.sv
module sdl_shift_reg #(
  parameter int unsigned LEN = 257,
  parameter int unsigned STW = 50
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sin,
  input  logic           shift_en,
  input  logic           load_en,
  input  logic [STW-1:0] status,
  output logic [LEN-1:0] sr_q
);
  localparam int unsigned PADW = LEN - STW;

  logic           sin_q;
  logic [LEN-1:0] sr_d;
  logic           sr_en;

  always_comb begin
    sr_d  = sr_q;
    sr_en = shift_en | load_en;
    if (load_en) begin
      sr_d = {{PADW{1'b0}}, status};
    end else if (shift_en) begin
      sr_d = {sr_q[LEN-2:0], sin_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_q <= 1'b0;
      sr_q  <= '0;
    end else begin
      sin_q <= sin;
      if (sr_en) sr_q <= sr_d;
    end
  end
endmodule

// File: rtl/sdl_latch_bank.sv
module sdl_latch_bank
  import sdl_pkg::*;
#(
  parameter int unsigned GSB = 256,
  parameter int unsigned CFB = 120
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lat_rise,
  input  logic           sel_ctl,
  input  logic [GSB-1:0] bus,
  input  logic           period_end,
  output logic [GSB-1:0] gs2_q,
  output logic [CFB-1:0] cfg2_q,
  output logic           restart_q
);
  localparam int unsigned CTB = CFB + 1;

  logic [GSB-1:0] gs1_q, gs2_d;
  logic [CTB-1:0] ctl1_q;
  logic           gs1_en, ctl1_en, cfg2_en, gs2_en, sync_wr, tmr;
  gs2_src_e       gs2_src;

  always_comb begin
    gs1_en  = lat_rise & ~sel_ctl;
    ctl1_en = lat_rise & sel_ctl;
    tmr     = ctl1_q[CFB];
    sync_wr = gs1_en & tmr;
    cfg2_en = sync_wr;
    if (sync_wr)         gs2_src = SRC_BUS;
    else if (period_end) gs2_src = SRC_STAGE1;
    else                 gs2_src = SRC_HOLD;
    gs2_en = (gs2_src != SRC_HOLD);
    unique case (gs2_src)
      SRC_BUS:    gs2_d = bus;
      SRC_STAGE1: gs2_d = gs1_q;
      default:    gs2_d = gs2_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gs1_q     <= '0;
      gs2_q     <= '0;
      ctl1_q    <= '0;
      cfg2_q    <= '0;
      restart_q <= 1'b0;
    end else begin
      if (gs1_en)  gs1_q  <= bus;
      if (ctl1_en) ctl1_q <= bus[CTB-1:0];
      if (gs2_en)  gs2_q  <= gs2_d;
      if (cfg2_en) cfg2_q <= ctl1_q[CFB-1:0];
      restart_q <= sync_wr;
    end
  end
endmodule

// File: rtl/serial_dual_latch.sv
module serial_dual_latch
  import sdl_pkg::*;
#(
  parameter int unsigned NCH = CH_DEF,
  parameter int unsigned GSW = GSW_DEF,
  parameter int unsigned DCW = DCW_DEF,
  parameter int unsigned BCW = BCW_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sin,
  input  logic               lat,
  input  logic               period_end,
  input  logic [NCH-1:0]     led_open,
  input  logic [NCH-1:0]     led_short,
  input  logic [NCH-1:0]     out_leak,
  input  logic               therm_err,
  input  logic               iref_short,
  output logic               sout,
  output logic [NCH*GSW-1:0] gs_data,
  output logic [NCH*DCW-1:0] dc_data,
  output logic [BCW-1:0]     bc_data,
  output logic               gs_restart
);
  localparam int unsigned GS_BITS = NCH * GSW;
  localparam int unsigned SR_LEN  = GS_BITS + 1;
  localparam int unsigned DC_BITS = NCH * DCW;
  localparam int unsigned CF_BITS = DC_BITS + BCW;
  localparam int unsigned ST_BITS = 3 * NCH + 2;

  logic              rst_i_n;
  logic [1:0]        rise;
  logic              sclk_rise, lat_rise;
  logic              load_pend, load_pend_d;
  logic [SR_LEN-1:0] sr_q;
  logic [ST_BITS-1:0] status;
  logic [CF_BITS-1:0] cfg2;

  sdl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sdl_edge_det #(.LANES(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_i_n),
    .lvl   ({lat, sclk}),
    .rise  (rise)
  );

  assign sclk_rise = rise[0];
  assign lat_rise  = rise[1];

  always_comb begin
    load_pend_d = lat_rise;
    status      = {iref_short, therm_err, out_leak, led_short, led_open};
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) load_pend <= 1'b0;
    else          load_pend <= load_pend_d;
  end

  sdl_shift_reg #(.LEN(SR_LEN), .STW(ST_BITS)) u_sr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .sin      (sin),
    .shift_en (sclk_rise),
    .load_en  (load_pend),
    .status   (status),
    .sr_q     (sr_q)
  );

  sdl_latch_bank #(.GSB(GS_BITS), .CFB(CF_BITS)) u_lat (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .lat_rise   (lat_rise),
    .sel_ctl    (sr_q[SR_LEN-1]),
    .bus        (sr_q[GS_BITS-1:0]),
    .period_end (period_end),
    .gs2_q      (gs_data),
    .cfg2_q     (cfg2),
    .restart_q  (gs_restart)
  );

  assign sout    = sr_q[SR_LEN-1];
  assign dc_data = cfg2[DC_BITS-1:0];
  assign bc_data = cfg2[CF_BITS-1:DC_BITS];
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker #(
  parameter int unsigned LEN = 257,
  parameter int unsigned GSB = 256,
  parameter int unsigned DCB = 112
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sclk_rise,
  input logic           lat_rise,
  input logic           load_pend,
  input logic           period_end,
  input logic [LEN-1:0] sr_q,
  input logic           sout,
  input logic [GSB-1:0] gs_data,
  input logic [DCB-1:0] dc_data,
  input logic           gs_restart
);
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sclk_rise) && !$past(load_pend)) |-> (sr_q[LEN-1:1] == $past(sr_q[LEN-2:0]))); // R1
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sclk_rise) && !$past(load_pend)) |-> $stable(sr_q)); // R1
  AST_RESTART_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    gs_restart |=> !gs_restart); // R5
  AST_RESTART_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    gs_restart |-> $past(lat_rise)); // R5
  AST_DC_WITH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dc_data) |-> gs_restart); // R5
  AST_GS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gs_data) |-> ($past(lat_rise) || $past(period_end))); // R7
  AST_STATUS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_pend) |-> !sout); // R8
endmodule

bind serial_dual_latch sdl_checker #(.LEN(SR_LEN), .GSB(GS_BITS), .DCB(DC_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk_rise  (sclk_rise),
  .lat_rise   (lat_rise),
  .load_pend  (load_pend),
  .period_end (period_end),
  .sr_q       (sr_q),
  .sout       (sout),
  .gs_data    (gs_data),
  .dc_data    (dc_data),
  .gs_restart (gs_restart)
);

// File: tb/serial_dual_latch_bench.sv
module serial_dual_latch_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         sclk, sin, lat, period_end;
  logic [15:0]  led_open, led_short, out_leak;
  logic         therm_err, iref_short;
  logic         sout;
  logic [255:0] gs_data;
  logic [111:0] dc_data;
  logic [7:0]   bc_data;
  logic         gs_restart;

  int total = 0;
  int bad   = 0;
  int restart_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_dual_latch u_serial_dual_latch (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sin(sin), .lat(lat),
    .period_end(period_end), .led_open(led_open), .led_short(led_short),
    .out_leak(out_leak), .therm_err(therm_err), .iref_short(iref_short),
    .sout(sout), .gs_data(gs_data), .dc_data(dc_data), .bc_data(bc_data),
    .gs_restart(gs_restart)
  );

  always @(posedge clk) if (gs_restart === 1'b1) restart_cnt <= restart_cnt + 1;

  task automatic chk(input string req, input logic [256:0] act, input logic [256:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk);
    sin  = b;
    sclk = 1'b1;
    wait_n(3);
    sclk = 1'b0;
    wait_n(3);
  endtask

  task automatic send_frame(input logic [256:0] v);
    for (int i = 256; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic pulse_lat();
    @(negedge clk);
    lat = 1'b1;
    wait_n(3);
    lat = 1'b0;
    wait_n(3);
  endtask

  task automatic pulse_period();
    @(negedge clk);
    period_end = 1'b1;
    @(negedge clk);
    period_end = 1'b0;
    wait_n(2);
  endtask

  function automatic logic [256:0] gs_frame(input logic [255:0] d);
    return {1'b0, d};
  endfunction

  function automatic logic [256:0] ctl_frame(input logic t, input logic [7:0] b, input logic [111:0] d);
    return {1'b1, 135'd0, t, b, d};
  endfunction

  localparam logic [255:0] PAT_A = {8{32'h1234_ABCD}};
  localparam logic [255:0] PAT_C = {16{16'hF00F}};
  localparam logic [255:0] PAT_E = {4{64'h0123_4567_89AB_CDEF}};
  localparam logic [111:0] DC_P  = {8{14'h2A5B}};
  localparam logic [7:0]   BC_P  = 8'h9C;

  task automatic t_reset();
    chk("R9 sout", {256'd0, sout}, 257'd0);
    chk("R9 gs_data", {1'b0, gs_data}, 257'd0);
    chk("R9 dc_data", {145'd0, dc_data}, 257'd0);
    chk("R9 bc_data/restart", {248'd0, bc_data, gs_restart}, 257'd0);
  endtask

  task automatic t_shift_chain();
    logic [256:0] model = '0;
    logic [256:0] pat = {1'b1, {8{32'hC35A_96E1}}};
    int miss = 0;
    for (int i = 256; i >= 0; i--) begin
      shift_bit(pat[i]);
      model = {model[255:0], pat[i]};
      if (sout !== model[256]) miss++;
    end
    chk("R1 per-shift sout tracking misses", 257'(miss), 257'd0);
    chk("R2 sout after full frame", {256'd0, sout}, {256'd0, pat[256]});
  endtask

  task automatic t_gs_plain();
    int rc0;
    send_frame(gs_frame(PAT_A));
    rc0 = restart_cnt;
    pulse_lat();
    chk("R6 gs_data unchanged without timing restart", {1'b0, gs_data}, 257'd0);
    chk("R6 no restart pulse", 257'(restart_cnt - rc0), 257'd0);
    chk("R8 sout low after status load", {256'd0, sout}, 257'd0);
  endtask

  task automatic t_status_read();
    logic [256:0] rd;
    logic [49:0]  exp_st;
    exp_st = {iref_short, therm_err, out_leak, led_short, led_open};
    for (int i = 256; i >= 0; i--) begin
      rd[i] = sout;
      shift_bit(1'b0);
    end
    chk("R8 status readout", rd, {207'd0, exp_st});
  endtask

  task automatic t_period_copy(input logic [255:0] exp, input string tag);
    pulse_period();
    chk(tag, {1'b0, gs_data}, {1'b0, exp});
  endtask

  task automatic t_ctl_write(input logic t);
    logic [255:0] gs0;
    logic [111:0] dc0;
    logic [7:0]   bc0;
    int rc0;
    gs0 = gs_data; dc0 = dc_data; bc0 = bc_data; rc0 = restart_cnt;
    send_frame(ctl_frame(t, BC_P, DC_P));
    pulse_lat();
    chk("R4 gs_data held on control write", {1'b0, gs_data}, {1'b0, gs0});
    chk("R4 dc/bc held on control write", {137'd0, dc_data, bc_data}, {137'd0, dc0, bc0});
    chk("R4 no restart on control write", 257'(restart_cnt - rc0), 257'd0);
  endtask

  task automatic t_gs_sync();
    int rc0;
    send_frame(gs_frame(PAT_C));
    rc0 = restart_cnt;
    pulse_lat();
    chk("R5 gs_data updated at once", {1'b0, gs_data}, {1'b0, PAT_C});
    chk("R5 dc/bc copied", {137'd0, dc_data, bc_data}, {137'd0, DC_P, BC_P});
    chk("R5 single restart cycle", 257'(restart_cnt - rc0), 257'd1);
  endtask

  task automatic t_gs_after_clear();
    send_frame(gs_frame(PAT_E));
    pulse_lat();
    chk("R6 gs_data held with restart bit cleared", {1'b0, gs_data}, {1'b0, PAT_C});
    chk("R6 dc/bc held with restart bit cleared", {137'd0, dc_data, bc_data}, {137'd0, DC_P, BC_P});
    t_period_copy(PAT_E, "R3 R7 new grayscale reaches output on period end");
  endtask

  initial begin
    #(100000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; sin = 1'b0; lat = 1'b0; period_end = 1'b0;
    led_open = 16'h8001; led_short = 16'h00F0; out_leak = 16'h1200;
    therm_err = 1'b1; iref_short = 1'b0;
    wait_n(4);
    t_reset();
    rst_n = 1'b1;
    wait_n(4);
    t_shift_chain();
    t_gs_plain();
    t_status_read();
    t_period_copy(PAT_A, "R3 R7 first stage copied on period end");
    t_ctl_write(1'b1);
    t_gs_sync();
    t_period_copy(PAT_C, "R7 period end keeps synchronised data");
    led_open = 16'h0102; led_short = 16'h4000; out_leak = 16'h0008;
    therm_err = 1'b0; iref_short = 1'b1;
    t_ctl_write(1'b0);
    t_status_read();
    t_gs_after_clear();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule